// File: doc/BRIEF.md
# Six-Decade BCD Tally Counter with Capture Register

This block is a decimal event counter of six BCD digits. It runs in a single system clock domain. Count pulses may arrive on either of two input pins, and the block combines the two with a logical OR. The block samples that combined signal through a synchroniser and advances the count by one on each falling edge it detects. The count ripples through all six decades in one system clock and wraps from 999999 to 000000.

The block also has a sticky overflow flag. This flag is set by the falling edge of a separate overflow pin, and it can be wired, for example, to the top bit of an upper decade or of an external prescaler. An active-low load strobe copies three things into an eight-digit holding register and an overflow latch:
- the six counter decades;
- two BCD digits supplied from outside, typically from a fast external prescaler;
- the overflow flag.

While load is held low, the holding register tracks its sources. When load returns high, the register freezes. An asynchronous active-low reset clears the count, the flag, the holding register and the overflow latch.

Top module: `decade_tally`

## Requirements
- R1: Each falling edge of the combined count signal (cnt_a OR cnt_b) increments the count by exactly one. No other activity changes the count.
- R2: Either count pin alone counts while the other is held low. Pulses on both pins that overlap in time form one combined pulse and count once.
- R3: Every decade stays in 0..9. A decade passing 9→0 carries into the next decade in the same step, and 999999 followed by one pulse gives 000000.
- R4: While rst_n is low, the count, the overflow flag, `held` and `ovf_out` are all zero. After reset, a load captures a count of zero.
- R5: The overflow flag is set by a falling edge of ovf_in. A rising edge alone does not set it. Once set, it stays set until reset.
- R6: A load captures ext_lo into held[3:0] and ext_hi into held[7:4]. It captures counter decade k (k=0 least significant) into held[8+4k+3 : 8+4k].
- R7: ovf_out changes only during a load, when it takes the value of the overflow flag. A flag that is set with no load leaves ovf_out unchanged.
- R8: While load_n is low, `held` and `ovf_out` follow new counts and new external digits. While load_n is high, both hold their values even when counting continues or the external digits change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_a | input | 1 | Count pulse source A |
| cnt_b | input | 1 | Count pulse source B (ORed with A) |
| ovf_in | input | 1 | Overflow event input; its falling edge sets the flag |
| load_n | input | 1 | Active-low capture strobe |
| ext_lo | input | 4 | External BCD digit, least significant position |
| ext_hi | input | 4 | External BCD digit, second position |
| held | output | 4*(NDEC+2) | Captured digits: counter decades above the two external digits |
| ovf_out | output | 1 | Overflow latch output |

## Verification
The internal count is visible only through a load. A wrong decade value, a missed carry or a double count therefore appears in `held` at the next capture. When load is held low, the error appears within four clocks of the count edge. A flag that sets on the wrong edge, or that is cleared when it should not be, shows on `ovf_out` at the first load after the event. A capture stage that leaks while load is high shows as a change in `held` with no strobe present. A second instance with two decades drives the wrap path through hundreds of cycles instead of a million.

// File: rtl/decade_tally_pkg.sv
package decade_tally_pkg;
  localparam int DIGIT_W = 4;
  localparam int EXT_DIGITS = 2;

  typedef logic [DIGIT_W-1:0] bcd_t;

  // next value of one decade, wrapping after nine
  function automatic bcd_t bcd_step(input bcd_t d);
    return (d == 4'd9) ? 4'd0 : d + 4'd1;
  endfunction

  // a decade at nine passes a carry when stepped
  function automatic logic bcd_at_top(input bcd_t d);
    return d == 4'd9;
  endfunction
endpackage

// File: rtl/edge_sampler.sv
module edge_sampler #(
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_LVL;
      sync_q <= RST_LVL;
      prev_q <= RST_LVL;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign fall  = prev_q & ~sync_q;
endmodule

// File: rtl/bcd_chain.sv
module bcd_chain
  import decade_tally_pkg::*;
#(
  parameter int NDEC = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  output logic [NDEC*DIGIT_W-1:0] digits
);
  logic [NDEC:0] carry;
  assign carry[0] = step;

  for (genvar k = 0; k < NDEC; k++) begin : g_dec
    bcd_t dig_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dig_q <= '0;
      else if (carry[k]) dig_q <= bcd_step(dig_q);
    end
    assign carry[k+1] = carry[k] & bcd_at_top(dig_q);
    assign digits[k*DIGIT_W +: DIGIT_W] = dig_q;
  end
endmodule

// File: rtl/capture_stage.sv
module capture_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_act,
  input  logic [W-1:0] data_in,
  input  logic         flag_in,
  output logic [W-1:0] held,
  output logic         flag_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= '0;
      flag_out <= 1'b0;
    end else if (load_act) begin
      held     <= data_in;
      flag_out <= flag_in;
    end
  end
endmodule

// File: rtl/decade_tally.sv
module decade_tally
  import decade_tally_pkg::*;
#(
  parameter int NDEC = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cnt_a,
  input  logic                             cnt_b,
  input  logic                             ovf_in,
  input  logic                             load_n,
  input  logic [DIGIT_W-1:0]               ext_lo,
  input  logic [DIGIT_W-1:0]               ext_hi,
  output logic [(NDEC+EXT_DIGITS)*DIGIT_W-1:0] held,
  output logic                             ovf_out
);
  localparam int CNT_W  = NDEC * DIGIT_W;
  localparam int HOLD_W = (NDEC + EXT_DIGITS) * DIGIT_W;

  // named internal events used by the checker
  logic             cnt_or;
  logic             cnt_lvl, count_fall;
  logic             ovf_lvl, ovf_fall;
  logic             load_lvl, load_fall_unused, load_act;
  logic [CNT_W-1:0] count_q;
  logic             ovf_ff;

  assign cnt_or = cnt_a | cnt_b;

  edge_sampler #(.RST_LVL(1'b0)) u_cnt_s (
    .clk(clk), .rst_n(rst_n), .din(cnt_or), .level(cnt_lvl), .fall(count_fall));
  edge_sampler #(.RST_LVL(1'b0)) u_ovf_s (
    .clk(clk), .rst_n(rst_n), .din(ovf_in), .level(ovf_lvl), .fall(ovf_fall));
  edge_sampler #(.RST_LVL(1'b1)) u_load_s (
    .clk(clk), .rst_n(rst_n), .din(load_n), .level(load_lvl), .fall(load_fall_unused));

  assign load_act = ~load_lvl;

  bcd_chain #(.NDEC(NDEC)) u_chain (
    .clk(clk), .rst_n(rst_n), .step(count_fall), .digits(count_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_ff <= 1'b0;
    else if (ovf_fall) ovf_ff <= 1'b1;
  end

  capture_stage #(.W(HOLD_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load_act(load_act),
    .data_in({count_q, ext_hi, ext_lo}), .flag_in(ovf_ff),
    .held(held), .flag_out(ovf_out));
endmodule

// File: rtl/decade_tally_chk.sv
module decade_tally_chk #(
  parameter int NDEC = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   count_fall,
  input logic                   ovf_fall,
  input logic                   load_act,
  input logic [NDEC*4-1:0]      count_q,
  input logic                   ovf_ff,
  input logic [7:0]             ext_bus,
  input logic [(NDEC+2)*4-1:0]  held,
  input logic                   ovf_out
);
  logic all_nine;
  always_comb begin
    all_nine = 1'b1;
    for (int k = 0; k < NDEC; k++)
      if (count_q[k*4 +: 4] != 4'd9) all_nine = 1'b0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < NDEC; k++)
        assert_digit_range_R3: assert (count_q[k*4 +: 4] <= 4'd9);
    end
  end

  assert_count_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count_fall |=> count_q != $past(count_q));
  assert_count_still_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !count_fall |=> $stable(count_q));
  assert_full_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_fall && all_nine) |=> count_q == '0);
  assert_flag_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_fall |=> ovf_ff);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ff |=> ovf_ff);
  assert_ext_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_act |=> held[7:0] == $past(ext_bus));
  assert_count_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_act |=> held[(NDEC+2)*4-1:8] == $past(count_q));
  assert_flag_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_act |=> ovf_out == $past(ovf_ff));
  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_act |=> ($stable(held) && $stable(ovf_out)));
endmodule

bind decade_tally decade_tally_chk #(.NDEC(NDEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .count_fall(count_fall), .ovf_fall(ovf_fall),
  .load_act(load_act), .count_q(count_q), .ovf_ff(ovf_ff),
  .ext_bus({ext_hi, ext_lo}), .held(held), .ovf_out(ovf_out));

// File: tb/decade_tally_bench.sv
module decade_tally_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_a = 1'b0, cnt_b = 1'b0, ovf_in = 1'b0, load_n = 1'b1;
  logic [3:0] ext_lo = 4'd0, ext_hi = 4'd0;
  logic [31:0] held;
  logic [15:0] held_s;
  logic ovf_out, ovf_out_s;

  always #10 clk = ~clk;

  decade_tally u_decade_tally (
    .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b), .ovf_in(ovf_in),
    .load_n(load_n), .ext_lo(ext_lo), .ext_hi(ext_hi), .held(held), .ovf_out(ovf_out));

  decade_tally #(.NDEC(2)) u_decade_tally_small (
    .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b), .ovf_in(ovf_in),
    .load_n(load_n), .ext_lo(ext_lo), .ext_hi(ext_hi), .held(held_s), .ovf_out(ovf_out_s));

  int checks = 0, failures = 0;
  int cnt_m = 0;
  logic ovf_ff_m = 1'b0, ovf_lat_m = 1'b0;
  bit done = 0;

  typedef struct {
    logic [31:0] m;
    logic [15:0] s;
    logic        ov;
    string       req;
  } exp_t;
  exp_t sb_q[$];
  event sb_ev;

  function automatic logic [31:0] to_bcd(input int v, input int nd);
    logic [31:0] r = '0;
    int x = v;
    for (int i = 0; i < nd; i++) begin
      r[i*4 +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_main();
    logic [31:0] b = to_bcd(cnt_m % 1000000, 6);
    return {b[23:0], ext_hi, ext_lo};
  endfunction

  function automatic logic [15:0] exp_small();
    logic [31:0] b = to_bcd(cnt_m % 100, 2);
    return {b[7:0], ext_hi, ext_lo};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares queued expectations when the driver signals a result
  initial forever begin
    @(sb_ev);
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.req, held, e.m);
      check(e.req, {16'd0, held_s}, {16'd0, e.s});
      check(e.req, {31'd0, ovf_out}, {31'd0, e.ov});
      check(e.req, {31'd0, ovf_out_s}, {31'd0, e.ov});
    end
  end

  task automatic pulse_a();
    cnt_a = 1'b1; repeat (2) @(negedge clk);
    cnt_a = 1'b0; repeat (2) @(negedge clk);
    cnt_m++;
  endtask

  task automatic pulse_b();
    cnt_b = 1'b1; repeat (2) @(negedge clk);
    cnt_b = 1'b0; repeat (2) @(negedge clk);
    cnt_m++;
  endtask

  task automatic pulse_both();
    cnt_a = 1'b1; @(negedge clk);
    cnt_b = 1'b1; @(negedge clk);
    cnt_a = 1'b0; @(negedge clk);
    cnt_b = 1'b0; repeat (2) @(negedge clk);
    cnt_m++;
  endtask

  task automatic ovf_pulse();
    ovf_in = 1'b1; repeat (3) @(negedge clk);
    ovf_in = 1'b0; repeat (3) @(negedge clk);
    ovf_ff_m = 1'b1;
  endtask

  // driver: strobe load, push the expectation, wake the monitor
  task automatic do_load(input string req);
    exp_t e;
    repeat (3) @(negedge clk);
    load_n = 1'b0; repeat (5) @(negedge clk);
    load_n = 1'b1; repeat (4) @(negedge clk);
    ovf_lat_m = ovf_ff_m;
    e.m = exp_main(); e.s = exp_small(); e.ov = ovf_lat_m; e.req = req;
    sb_q.push_back(e);
    -> sb_ev;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] snap_m;
    logic [15:0] snap_s;
    repeat (3) @(negedge clk);
    // R4 reset state
    check("R4 reset held", held, 32'd0);
    check("R4 reset ovf", {31'd0, ovf_out}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    ext_lo = 4'd3; ext_hi = 4'd7;

    pulse_a();  do_load("R1 R6 single pulse on A");
    pulse_b();  do_load("R2 pulse on B alone");
    pulse_both(); do_load("R2 overlapping pulses count once");

    // R5 rising edge only must not set; R7 flag not visible without load
    ovf_in = 1'b1; repeat (4) @(negedge clk);
    do_load("R5 rising edge alone leaves flag clear");
    ovf_in = 1'b0; repeat (4) @(negedge clk);
    ovf_ff_m = 1'b1;
    check("R7 ovf_out waits for load", {31'd0, ovf_out}, 32'd0);
    do_load("R5 R7 falling edge sets flag, load shows it");
    ovf_pulse(); ovf_pulse();
    do_load("R5 flag stays set");

    while (cnt_m < 99) pulse_a();
    do_load("R3 count 99");
    pulse_b(); do_load("R3 carry to 100, small wraps");
    ext_lo = 4'd9; ext_hi = 4'd1;
    while (cnt_m < 1099) pulse_a();
    do_load("R6 count 1099 new ext digits");
    pulse_a(); do_load("R3 double carry to 1100");

    // R8 follow while low, then freeze
    load_n = 1'b0; repeat (4) @(negedge clk);
    pulse_a(); repeat (3) @(negedge clk);
    check("R8 follows count", held, exp_main());
    ext_lo = 4'd5; repeat (4) @(negedge clk);
    check("R8 follows ext digit", held, exp_main());
    check("R8 follows ext digit small", {16'd0, held_s}, {16'd0, exp_small()});
    load_n = 1'b1; repeat (4) @(negedge clk);
    snap_m = exp_main(); snap_s = exp_small();
    pulse_b(); ext_hi = 4'd2; ext_lo = 4'd8; repeat (4) @(negedge clk);
    check("R8 frozen after release", held, snap_m);
    check("R8 frozen after release small", {16'd0, held_s}, {16'd0, snap_s});
    check("R7 ovf_out held", {31'd0, ovf_out}, 32'd1);
    do_load("R8 next load picks up hidden count");

    // R4 reset mid-run
    @(negedge clk); rst_n = 1'b0; repeat (2) @(negedge clk);
    check("R4 reset clears held", held, 32'd0);
    check("R4 reset clears ovf_out", {31'd0, ovf_out}, 32'd0);
    rst_n = 1'b1; repeat (2) @(negedge clk);
    cnt_m = 0; ovf_ff_m = 1'b0;
    do_load("R4 count and flag zero after reset");
    pulse_both(); do_load("R1 counting resumes after reset");

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule